// File: doc/BRIEF.md
# Quasi-Resonant Valley-Switch Gate Timing Engine

This block sequences the power switch of a primary-side-regulated flyback converter, one switching cycle at a time. All analog sensing is done outside the block and arrives as synchronous digital flags. These flags are:

- a peak-current comparator;
- an over-current comparator;
- a current-sense-too-low comparator;
- a flag saying the feedback winding is still above its discharge-end threshold;
- a ringing-valley pulse;
- a line-level flag, a load-level flag and a constant-current mode flag.

All durations are counted in clock ticks. Every limit is a parameter. The defaults assume a 100 MHz clock.

Each cycle runs through four phases:

1. **On phase.** The gate is high. Current-sense events are ignored for a blanking interval at the start of the phase. The phase ends on a peak-current trip, an over-current trip, a failed current-sense plausibility test, or the maximum on-time.
2. **Blanking phase.** Feedback sampling is suppressed for a length chosen by the mode flags.
3. **Discharge phase.** The block waits for the feedback to fall. At the fall it records the discharge time, pulses a sample strobe and holds the last tracked feedback code.
4. **Ring phase.** The block waits for a valley to switch on again.

A minimum period limits the switching frequency. A maximum period forces a turn-on when no valley or no discharge end is ever seen.

Top module: `qr_gate_timer`

## Requirements
- R1: While reset is asserted, and directly after it, `gate_o`, `sample_o`, `over_cur_o` and `short_det_o` are 0, and `tdis_o` and `fb_hold_o` read 0.
- R2: During the first LEB_CYC cycles of an on phase, `cs_peak_i` and `cs_fault_i` have no effect. The gate stays high through those cycles.
- R3: Count on-cycles from 0. If `cs_peak_i` is high in on-cycle j, with j >= LEB_CYC, the gate is low from the next cycle, so the on length is j+1.
- R4: With no trip, the gate stays high for exactly MAX_ON_CYC cycles.
- R5: If `cs_fault_i` is high in on-cycle j, with j >= LEB_CYC, the on length is j+1. `over_cur_o` is high in the first low cycle.
- R6: The plausibility check looks at on-cycle SHORT_HI_CYC-1 when `line_high_i` was 1 in the cycle before turn-on, and at on-cycle SHORT_LO_CYC-1 otherwise. If `cs_low_i` is high in that cycle, the on length equals that check time and `short_det_o` is high in the first low cycle. A phase that ends earlier raises no `short_det_o`.
- R7: The post-turn-off blanking lasts BLK_CC_CYC cycles when `cc_mode_i` is 1, BLK_HI_CYC when only `load_high_i` is 1, and BLK_LO_CYC otherwise. The flags are sampled in the last on cycle. During blanking, `fb_above_i` is ignored, so a feedback level that is already low yields a discharge time equal to the blanking length.
- R8: Count low cycles from 0 at turn-off. The discharge time is the index of the first cycle after blanking with `fb_above_i` low. It appears on `tdis_o` one cycle later.
- R9: `sample_o` is a one-cycle pulse in the cycle after the discharge end is detected. In that same cycle `fb_hold_o` shows `fb_code_i` from the last discharge-phase cycle in which `fb_above_i` was high.
- R10: After the discharge end, a `valley_i` pulse in cycle k turns the gate on in cycle k+1, provided the minimum period is met. A valley seen before the discharge end has no effect.
- R11: A valley is ignored when fewer than MIN_PERIOD_CYC-1 cycles have passed since the last rise. A valley at exactly that count gives a rise-to-rise period of MIN_PERIOD_CYC.
- R12: Without an accepted valley, the next rise comes exactly MAX_PERIOD_CYC cycles after the previous one (or after reset release). If no discharge end was seen, `tdis_o` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_peak_i | input | 1 | Current sense reached the peak demand |
| cs_fault_i | input | 1 | Current sense above the over-current level |
| cs_low_i | input | 1 | Current sense below the plausibility floor |
| fb_above_i | input | 1 | Feedback winding above the discharge-end threshold |
| fb_code_i | input | FB_W | Digitised feedback level |
| valley_i | input | 1 | Resonant valley detected |
| line_high_i | input | 1 | High input line |
| load_high_i | input | 1 | High output load |
| cc_mode_i | input | 1 | Constant-current control active |
| gate_o | output | 1 | Switch gate command |
| sample_o | output | 1 | Feedback hold strobe |
| fb_hold_o | output | FB_W | Held feedback code |
| tdis_o | output | $clog2(MAX_PERIOD_CYC+1) | Last measured discharge time in cycles |
| over_cur_o | output | 1 | Over-current trip pulse |
| short_det_o | output | 1 | Sense-short trip pulse |

## Verification
Several properties are checked on every cycle:

- the blanking interval always holds the gate high;
- the last allowed on-cycle always ends the phase;
- a trip always drops the gate;
- strobes are single pulses, and a measured discharge time never falls below the blanking length;
- every turn-on comes from a valley or the period cap, never before the minimum period;
- an accepted valley always switches on.

The exact on lengths, blanking lengths per mode, the line-dependent check time, the held feedback code, and the rejection of early or premature valleys show only in the directed scenarios.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;
  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_BLANK = 2'd1,
    ST_DISCH = 2'd2,
    ST_RING  = 2'd3
  } qr_state_e;
endpackage

// File: rtl/qr_on_timer.sv
module qr_on_timer #(
  parameter int LEB_CYC      = 25,
  parameter int MAX_ON_CYC   = 2000,
  parameter int SHORT_LO_CYC = 450,
  parameter int SHORT_HI_CYC = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic on_i,
  input  logic line_high_i,
  input  logic cs_peak_i,
  input  logic cs_fault_i,
  input  logic cs_low_i,
  output logic off_o,
  output logic ocp_o,
  output logic short_o
);
  localparam int OW = $clog2(MAX_ON_CYC + 1);
  localparam logic [OW-1:0] LEB_V    = OW'(LEB_CYC);
  localparam logic [OW-1:0] ON_LAST  = OW'(MAX_ON_CYC - 1);
  localparam logic [OW-1:0] CHK_LO_L = OW'(SHORT_LO_CYC - 1);
  localparam logic [OW-1:0] CHK_HI_L = OW'(SHORT_HI_CYC - 1);

  logic [OW-1:0] on_cnt_q;
  logic          chk_hi_q;
  logic          armed;
  logic          peak_trip;
  logic          max_trip;
  logic [OW-1:0] chk_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt_q <= '0;
      chk_hi_q <= 1'b0;
    end else if (start_i) begin
      on_cnt_q <= '0;
      chk_hi_q <= line_high_i;
    end else if (on_i && on_cnt_q != ON_LAST) begin
      on_cnt_q <= on_cnt_q + 1'b1;
    end
  end

  always_comb begin
    armed     = on_cnt_q >= LEB_V;
    chk_last  = chk_hi_q ? CHK_HI_L : CHK_LO_L;
    peak_trip = on_i & armed & cs_peak_i;
    ocp_o     = on_i & armed & cs_fault_i;
    short_o   = on_i & cs_low_i & (on_cnt_q == chk_last);
    max_trip  = on_i & (on_cnt_q == ON_LAST);
    off_o     = peak_trip | ocp_o | short_o | max_trip;
  end

  assert_leb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && !armed) |=> on_i);
  assert_on_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && on_cnt_q == ON_LAST) |=> !on_i);
  assert_ocp_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_o |=> !on_i);
  assert_short_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |=> !on_i);
endmodule

// File: rtl/qr_dis_meter.sv
module qr_dis_meter #(
  parameter int BLK_LO_CYC     = 130,
  parameter int BLK_HI_CYC     = 180,
  parameter int BLK_CC_CYC     = 220,
  parameter int MAX_PERIOD_CYC = 4500,
  parameter int FB_W           = 10,
  localparam int PW            = $clog2(MAX_PERIOD_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            off_start_i,
  input  logic            blank_i,
  input  logic            dis_i,
  input  logic            load_high_i,
  input  logic            cc_mode_i,
  input  logic            fb_above_i,
  input  logic [FB_W-1:0] fb_code_i,
  output logic            blank_done_o,
  output logic            dis_end_o,
  output logic            sample_o,
  output logic [FB_W-1:0] fb_hold_o,
  output logic [PW-1:0]   tdis_o
);
  localparam logic [PW-1:0] BL_LO = PW'(BLK_LO_CYC - 1);
  localparam logic [PW-1:0] BL_HI = PW'(BLK_HI_CYC - 1);
  localparam logic [PW-1:0] BL_CC = PW'(BLK_CC_CYC - 1);

  logic [PW-1:0]   off_cnt_q;
  logic [PW-1:0]   blk_last_q;
  logic [FB_W-1:0] track_q;
  logic [FB_W-1:0] hold_q;
  logic [PW-1:0]   tdis_q;
  logic            sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt_q  <= '0;
      blk_last_q <= BL_LO;
    end else if (off_start_i) begin
      off_cnt_q  <= '0;
      blk_last_q <= cc_mode_i ? BL_CC : (load_high_i ? BL_HI : BL_LO);
    end else if (off_cnt_q != '1) begin
      off_cnt_q <= off_cnt_q + 1'b1;
    end
  end

  always_comb begin
    blank_done_o = blank_i & (off_cnt_q == blk_last_q);
    dis_end_o    = dis_i & ~fb_above_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      track_q  <= '0;
      hold_q   <= '0;
      tdis_q   <= '0;
      sample_q <= 1'b0;
    end else begin
      if (dis_i && fb_above_i) track_q <= fb_code_i;
      sample_q <= dis_end_o;
      if (dis_end_o) begin
        hold_q <= track_q;
        tdis_q <= off_cnt_q;
      end
    end
  end

  assign sample_o  = sample_q;
  assign fb_hold_o = hold_q;
  assign tdis_o    = tdis_q;

  assert_sample_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |=> !sample_q);
  assert_tdis_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> tdis_q > blk_last_q);
  assert_blank_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> !sample_q);
endmodule

// File: rtl/qr_period_guard.sv
module qr_period_guard #(
  parameter int MIN_PERIOD_CYC = 1316,
  parameter int MAX_PERIOD_CYC = 4500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic min_ok_o,
  output logic max_hit_o
);
  localparam int PW = $clog2(MAX_PERIOD_CYC + 1);
  localparam logic [PW-1:0] MIN_LAST = PW'(MIN_PERIOD_CYC - 1);
  localparam logic [PW-1:0] MAX_LAST = PW'(MAX_PERIOD_CYC - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (cnt_q != MAX_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign min_ok_o  = cnt_q >= MIN_LAST;
  assign max_hit_o = cnt_q == MAX_LAST;

  assert_min_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q >= MIN_LAST);
  assert_max_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_hit_o |=> cnt_q == '0);
endmodule

// File: rtl/qr_gate_timer.sv
module qr_gate_timer
  import qr_gate_pkg::*;
#(
  parameter int LEB_CYC        = 25,
  parameter int MAX_ON_CYC     = 2000,
  parameter int SHORT_LO_CYC   = 450,
  parameter int SHORT_HI_CYC   = 150,
  parameter int BLK_LO_CYC     = 130,
  parameter int BLK_HI_CYC     = 180,
  parameter int BLK_CC_CYC     = 220,
  parameter int MIN_PERIOD_CYC = 1316,
  parameter int MAX_PERIOD_CYC = 4500,
  parameter int FB_W           = 10,
  localparam int PW            = $clog2(MAX_PERIOD_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_peak_i,
  input  logic            cs_fault_i,
  input  logic            cs_low_i,
  input  logic            fb_above_i,
  input  logic [FB_W-1:0] fb_code_i,
  input  logic            valley_i,
  input  logic            line_high_i,
  input  logic            load_high_i,
  input  logic            cc_mode_i,
  output logic            gate_o,
  output logic            sample_o,
  output logic [FB_W-1:0] fb_hold_o,
  output logic [PW-1:0]   tdis_o,
  output logic            over_cur_o,
  output logic            short_det_o
);
  qr_state_e state_q, state_d;
  logic off_req, ocp, short_hit;
  logic blank_done, dis_end;
  logic min_ok, max_hit;
  logic turn_on, off_start;
  logic ocp_q, short_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ON:    if (off_req) state_d = ST_BLANK;
      ST_BLANK: if (max_hit) state_d = ST_ON;
                else if (blank_done) state_d = ST_DISCH;
      ST_DISCH: if (max_hit) state_d = ST_ON;
                else if (dis_end) state_d = ST_RING;
      ST_RING:  if (max_hit || (valley_i && min_ok)) state_d = ST_ON;
      default:  state_d = ST_RING;
    endcase
    turn_on   = (state_q != ST_ON) && (state_d == ST_ON);
    off_start = (state_q == ST_ON) && off_req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RING;
      ocp_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ocp_q   <= ocp;
      short_q <= short_hit;
    end
  end

  assign gate_o      = (state_q == ST_ON);
  assign over_cur_o  = ocp_q;
  assign short_det_o = short_q;

  qr_on_timer #(
    .LEB_CYC(LEB_CYC), .MAX_ON_CYC(MAX_ON_CYC),
    .SHORT_LO_CYC(SHORT_LO_CYC), .SHORT_HI_CYC(SHORT_HI_CYC)
  ) u_on (
    .clk_i, .rst_ni,
    .start_i(turn_on), .on_i(gate_o), .line_high_i,
    .cs_peak_i, .cs_fault_i, .cs_low_i,
    .off_o(off_req), .ocp_o(ocp), .short_o(short_hit)
  );

  qr_dis_meter #(
    .BLK_LO_CYC(BLK_LO_CYC), .BLK_HI_CYC(BLK_HI_CYC), .BLK_CC_CYC(BLK_CC_CYC),
    .MAX_PERIOD_CYC(MAX_PERIOD_CYC), .FB_W(FB_W)
  ) u_dis (
    .clk_i, .rst_ni,
    .off_start_i(off_start),
    .blank_i(state_q == ST_BLANK), .dis_i(state_q == ST_DISCH),
    .load_high_i, .cc_mode_i, .fb_above_i, .fb_code_i,
    .blank_done_o(blank_done), .dis_end_o(dis_end),
    .sample_o, .fb_hold_o, .tdis_o
  );

  qr_period_guard #(
    .MIN_PERIOD_CYC(MIN_PERIOD_CYC), .MAX_PERIOD_CYC(MAX_PERIOD_CYC)
  ) u_per (
    .clk_i, .rst_ni, .start_i(turn_on),
    .min_ok_o(min_ok), .max_hit_o(max_hit)
  );

  assert_valley_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RING && valley_i && min_ok) |=> gate_o);
  assert_on_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(max_hit || (state_q == ST_RING && valley_i)));
  assert_force_on_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_hit && !gate_o) |=> gate_o);
  assert_trip_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_cur_o || short_det_o) |-> !gate_o);
endmodule

// File: tb/qr_gate_timer_tb_top.sv
module qr_gate_timer_tb_top;
  localparam int LEB = 5, MAXON = 40, SLO = 30, SHI = 12;
  localparam int BLO = 8, BHI = 11, BCC = 14, MINP = 60, MAXP = 120, FBW = 8;
  localparam int PW = $clog2(MAXP + 1);
  localparam int NEVER = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_peak_i = 0, cs_fault_i = 0, cs_low_i = 0, fb_above_i = 1, valley_i = 0;
  logic line_high_i = 0, load_high_i = 0, cc_mode_i = 0;
  logic [FBW-1:0] fb_code_i = '0;
  logic gate_o, sample_o, over_cur_o, short_det_o;
  logic [FBW-1:0] fb_hold_o;
  logic [PW-1:0] tdis_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  qr_gate_timer #(
    .LEB_CYC(LEB), .MAX_ON_CYC(MAXON), .SHORT_LO_CYC(SLO), .SHORT_HI_CYC(SHI),
    .BLK_LO_CYC(BLO), .BLK_HI_CYC(BHI), .BLK_CC_CYC(BCC),
    .MIN_PERIOD_CYC(MINP), .MAX_PERIOD_CYC(MAXP), .FB_W(FBW)
  ) dut_i (
    .clk_i(clk), .rst_ni, .cs_peak_i, .cs_fault_i, .cs_low_i, .fb_above_i, .fb_code_i,
    .valley_i, .line_high_i, .load_high_i, .cc_mode_i, .gate_o, .sample_o, .fb_hold_o,
    .tdis_o, .over_cur_o, .short_det_o
  );

  function automatic logic [FBW-1:0] code_of(int k);
    return FBW'(k * 7 + 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(logic v);
    int n = 0;
    while (gate_o !== v && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic align();
    wait_level(1'b0);
    wait_level(1'b1);
  endtask

  task automatic on_phase(int peak_at, int fault_at, logic low,
                          output int len, output int ocp, output int shrt);
    len = 0;
    while (gate_o && len < 2000) begin
      cs_peak_i  = (len == peak_at);
      cs_fault_i = (len == fault_at);
      cs_low_i   = low;
      @(negedge clk);
      len++;
    end
    ocp = int'(over_cur_o);
    shrt = int'(short_det_o);
    cs_peak_i = 0; cs_fault_i = 0; cs_low_i = 0;
  endtask

  task automatic off_phase(int fall_at, int valley_at, output int len,
                           output int samp_k, output int samp_n,
                           output int tdis, output int hold);
    int k = 0;
    samp_k = -1; samp_n = 0; tdis = -1; hold = -1;
    while (!gate_o && k < 2000) begin
      fb_above_i = (k < fall_at);
      valley_i   = (k == valley_at);
      fb_code_i  = code_of(k);
      if (sample_o) begin
        samp_n++; samp_k = k; tdis = int'(tdis_o); hold = int'(fb_hold_o);
      end
      @(negedge clk);
      k++;
    end
    len = k;
    fb_above_i = 1; valley_i = 0;
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R1 gate", int'(gate_o), 0);
    chk("R1 sample", int'(sample_o), 0);
    chk("R1 tdis", int'(tdis_o), 0);
    chk("R1 hold", int'(fb_hold_o), 0);
    chk("R1 flags", int'(over_cur_o) + int'(short_det_o), 0);
    rst_ni = 1'b1;
    while (!gate_o && n < 1000) begin @(negedge clk); n++; end
    chk("R12 first rise", n, MAXP);
  endtask

  task automatic t_max_on();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, -1, 0, l, o, s);
    chk("R4 on length", l, MAXON);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
    chk("R12 forced low length", lo, MAXP - MAXON);
    chk("R12 no strobe", sn, 0);
    chk("R12 tdis kept", int'(tdis_o), 0);
  endtask

  task automatic t_leb();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(2, 3, 0, l, o, s);
    chk("R2 blanked trips", l, MAXON);
    chk("R2 no ocp flag", o, 0);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
  endtask

  task automatic t_peak();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(LEB, -1, 0, l, o, s);
    chk("R3 peak at blank end", l, LEB + 1);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
    chk("R12 period after short on", l + lo, MAXP);
    on_phase(20, -1, 0, l, o, s);
    chk("R3 peak mid", l, 21);
    chk("R3 no flags", o + s, 0);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
  endtask

  task automatic t_ocp();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, 7, 0, l, o, s);
    chk("R5 ocp length", l, 8);
    chk("R5 ocp flag", o, 1);
    chk("R5 no short flag", s, 0);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
  endtask

  task automatic t_short();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, -1, 1, l, o, s);
    chk("R6 low line check", l, SLO);
    chk("R6 short flag", s, 1);
    line_high_i = 1;
    align();
    on_phase(-1, -1, 1, l, o, s);
    chk("R6 high line check", l, SHI);
    chk("R6 short flag hi", s, 1);
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
    on_phase(8, -1, 1, l, o, s);
    chk("R6 earlier peak", l, 9);
    chk("R6 no short flag", s, 0);
    line_high_i = 0;
    off_phase(NEVER, -1, lo, sk, sn, td, hd);
  endtask

  task automatic blank_case(logic ld, logic cc, int exp, string tag);
    int l, o, s, lo, sk, sn, td, hd;
    load_high_i = ld; cc_mode_i = cc;
    on_phase(-1, -1, 0, l, o, s);
    off_phase(0, -1, lo, sk, sn, td, hd);
    chk(tag, td, exp);
    chk("R7 strobe slot", sk, exp + 1);
    load_high_i = 0; cc_mode_i = 0;
  endtask

  task automatic t_blank();
    blank_case(0, 0, BLO, "R7 normal blank");
    blank_case(1, 0, BHI, "R7 high load blank");
    blank_case(1, 1, BCC, "R7 cc blank");
    blank_case(0, 1, BCC, "R7 cc only blank");
  endtask

  task automatic t_tdis_hold();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, -1, 0, l, o, s);
    off_phase(20, -1, lo, sk, sn, td, hd);
    chk("R8 tdis", td, 20);
    chk("R9 strobe cycle", sk, 21);
    chk("R9 single strobe", sn, 1);
    chk("R9 held code", hd, int'(code_of(19)));
    chk("R8 tdis persists", int'(tdis_o), 20);
  endtask

  task automatic t_valley();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, -1, 0, l, o, s);
    off_phase(20, 25, lo, sk, sn, td, hd);
    chk("R10 valley turn-on", lo, 26);
    on_phase(-1, -1, 0, l, o, s);
    off_phase(30, 15, lo, sk, sn, td, hd);
    chk("R10 valley before end ignored", lo, MAXP - MAXON);
    chk("R8 late fall", td, 30);
  endtask

  task automatic t_min_period();
    int l, o, s, lo, sk, sn, td, hd;
    on_phase(-1, -1, 0, l, o, s);
    off_phase(12, 15, lo, sk, sn, td, hd);
    chk("R11 early valley ignored", l + lo, MAXP);
    on_phase(-1, -1, 0, l, o, s);
    off_phase(12, 19, lo, sk, sn, td, hd);
    chk("R11 valley at min period", l + lo, MINP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_max_on();
    t_leb();
    t_peak();
    t_ocp();
    t_short();
    t_blank();
    t_tdis_hold();
    t_valley();
    t_min_period();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule